// File: doc/BRIEF.md
# Protection-Key Rights Checker

This block refines the access rights of a memory reference that has already been translated. The translation entry supplies an 18-bit protection key and its own read/write/execute rights. The checker searches a small, fully associative set of key registers for that key. On a hit, the effective rights are the bitwise AND of the matching register's rights and the translation's rights. The result is compared against the kind of access that was requested.

The check sits beside the pipeline and does not gate the cache. The verdict is registered and appears one cycle after the reference is presented, so the access can still be aborted at that point. A reference whose key matches no valid register raises a key-miss fault, which is distinct from a rights fault.

Software fills the key registers through a single write port. The registers carry no context tag, so a context switch must clear all of them with one flush command.

Top module: `prot_key_check`

## Requirements
- R1: After reset every key register is invalid and `resultValid`, `keyMissFault`, `rightsFault` and `effRights` are all low.
- R2: A reference presented with `lookupValid` high in cycle N produces its verdict on the outputs in cycle N+1 only. `resultValid` is high in exactly those cycles, and all outputs are low in any cycle not preceded by a lookup.
- R3: If no valid register holds `lookupKey`, the result carries `keyMissFault`=1, `rightsFault`=0 and `effRights`=0.
- R4: On a key hit, `effRights` equals the matching register's rights ANDed with `lookupRights`. The rights bits are bit0 read, bit1 write and bit2 execute.
- R5: On a hit, `rightsFault` is set when the bit for the requested access is clear in `effRights`. `lookupAccess` is coded 00 read, 01 write, 10 execute. Code 11 requests no right and always faults on a hit.
- R6: `keyMissFault` and `rightsFault` are never high together.
- R7: A write with `regWrEn` loads the register at `regWrIdx` with `regWrKey`, `regWrRights` and the valid flag `regWrValid`; writing valid=0 removes the entry. A lookup in the same cycle as a write sees the table as it stood before the write.
- R8: A valid write whose key equals that of another valid register invalidates that other register, so at most one register ever matches.
- R9: `flushReq` invalidates every register at the next edge. A write in the same cycle is discarded, and a lookup in that cycle still sees the old table.
- R10: Any register index, up to the last one, can hold any key and be hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A reference is presented this cycle |
| lookupKey | input | KEY_W | Protection key from the translation entry |
| lookupRights | input | 3 | Translation rights (bit0 R, bit1 W, bit2 X) |
| lookupAccess | input | 2 | Requested access: 00 read, 01 write, 10 execute, 11 none |
| regWrEn | input | 1 | Software register write strobe |
| regWrIdx | input | IDX_W | Register index to write |
| regWrKey | input | KEY_W | Key to store |
| regWrRights | input | 3 | Rights to store |
| regWrValid | input | 1 | Valid flag to store |
| flushReq | input | 1 | Invalidate all registers |
| resultValid | output | 1 | Verdict present for the previous cycle's reference |
| keyMissFault | output | 1 | No valid register matched the key |
| rightsFault | output | 1 | Requested access not granted by the effective rights |
| effRights | output | 3 | Effective rights of the checked reference |

## Verification
The bench builds the checker with four registers and 6-bit keys. A small key space makes duplicate keys, a completely full table and the last index easy to reach in a short sequence. It also lets one key value be reused after a purge or flush, so stale state would show up as a wrong hit. With so few registers, the exclusivity of matches after a replacing write can be observed directly: the surviving copy is removed and a lookup of that key must then report a key miss.

// File: rtl/prot_key_pkg.sv
package prot_key_pkg;

  localparam int RIGHTS_W = 3;
  localparam int RIGHT_RD = 0;
  localparam int RIGHT_WR = 1;
  localparam int RIGHT_EX = 2;

  typedef logic [RIGHTS_W-1:0] rights_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_NONE  = 2'b11
  } accKind_e;

  // strobes from control to the key-register datapath
  typedef struct packed {
    logic flushAll;
    logic writeCommit;
    logic dupPurge;
    logic capture;
  } tableStrobe_t;

  function automatic rights_t needMask(logic [1:0] acc);
    rights_t m;
    m = '0;
    case (acc)
      ACC_READ:  m[RIGHT_RD] = 1'b1;
      ACC_WRITE: m[RIGHT_WR] = 1'b1;
      ACC_EXEC:  m[RIGHT_EX] = 1'b1;
      default:   m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/key_table_dp.sv
module key_table_dp
  import prot_key_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int KEY_W       = 18,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  tableStrobe_t       strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [KEY_W-1:0]   wrKey,
  input  rights_t            wrRights,
  input  logic               wrValid,
  input  logic [KEY_W-1:0]   lkKey,
  input  rights_t            lkRights,
  output logic               hitAny,
  output rights_t            effRightsComb
);

  logic [NUM_ENTRIES-1:0]          matchVec;
  logic [NUM_ENTRIES-1:0]          dupVec;
  logic [NUM_ENTRIES*RIGHTS_W-1:0] hitRightsFlat;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
    logic             entValid;
    logic [KEY_W-1:0] entKey;
    rights_t          entRights;
    logic             isTarget;

    assign isTarget = (wrIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid  <= 1'b0;
        entKey    <= '0;
        entRights <= '0;
      end else if (strobe.flushAll) begin
        entValid <= 1'b0;
      end else if (strobe.writeCommit && isTarget) begin
        entValid  <= wrValid;
        entKey    <= wrKey;
        entRights <= wrRights;
      end else if (strobe.dupPurge && dupVec[i]) begin
        entValid <= 1'b0;
      end
    end

    assign matchVec[i] = entValid && (entKey == lkKey);
    assign dupVec[i]   = entValid && (entKey == wrKey) && !isTarget;
    assign hitRightsFlat[i*RIGHTS_W +: RIGHTS_W] = matchVec[i] ? entRights : '0;
  end

  rights_t keyRights;
  always_comb begin
    keyRights = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      keyRights = keyRights | hitRightsFlat[i*RIGHTS_W +: RIGHTS_W];
    end
  end

  assign hitAny        = |matchVec;
  assign effRightsComb = keyRights & lkRights;

endmodule

// File: rtl/key_check_ctrl.sv
module key_check_ctrl
  import prot_key_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         wrValid,
  input  logic         flushReq,
  input  logic         lkValid,
  input  logic [1:0]   lkAccess,
  input  logic         hitAny,
  input  rights_t      effRightsComb,
  output tableStrobe_t strobe,
  output logic         resultValid,
  output logic         keyMissFault,
  output logic         rightsFault,
  output rights_t      effRights
);

  always_comb begin
    strobe.flushAll    = flushReq;
    strobe.writeCommit = wrEn && !flushReq;
    strobe.dupPurge    = wrEn && wrValid && !flushReq;
    strobe.capture     = lkValid;
  end

  logic grantOk;
  assign grantOk = |(effRightsComb & needMask(lkAccess));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid  <= 1'b0;
      keyMissFault <= 1'b0;
      rightsFault  <= 1'b0;
      effRights    <= '0;
    end else if (strobe.capture) begin
      resultValid  <= 1'b1;
      keyMissFault <= !hitAny;
      rightsFault  <= hitAny && !grantOk;
      effRights    <= hitAny ? effRightsComb : '0;
    end else begin
      resultValid  <= 1'b0;
      keyMissFault <= 1'b0;
      rightsFault  <= 1'b0;
      effRights    <= '0;
    end
  end

endmodule

// File: rtl/prot_key_check.sv
module prot_key_check
  import prot_key_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int KEY_W       = 18,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [KEY_W-1:0] lookupKey,
  input  logic [2:0]       lookupRights,
  input  logic [1:0]       lookupAccess,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regWrIdx,
  input  logic [KEY_W-1:0] regWrKey,
  input  logic [2:0]       regWrRights,
  input  logic             regWrValid,
  input  logic             flushReq,
  output logic             resultValid,
  output logic             keyMissFault,
  output logic             rightsFault,
  output logic [2:0]       effRights
);

  tableStrobe_t strobe;
  logic         hitAny;
  rights_t      effRightsComb;

  key_table_dp #(.NUM_ENTRIES(NUM_ENTRIES), .KEY_W(KEY_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrIdx(regWrIdx), .wrKey(regWrKey), .wrRights(regWrRights), .wrValid(regWrValid),
    .lkKey(lookupKey), .lkRights(lookupRights),
    .hitAny(hitAny), .effRightsComb(effRightsComb)
  );

  key_check_ctrl ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrEn), .wrValid(regWrValid), .flushReq(flushReq),
    .lkValid(lookupValid), .lkAccess(lookupAccess),
    .hitAny(hitAny), .effRightsComb(effRightsComb),
    .strobe(strobe),
    .resultValid(resultValid), .keyMissFault(keyMissFault),
    .rightsFault(rightsFault), .effRights(effRights)
  );

endmodule

// File: rtl/key_check_sva.sv
module key_check_sva
  import prot_key_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int KEY_W       = 18,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic [KEY_W-1:0] lookupKey,
  input logic [2:0]       lookupRights,
  input logic [1:0]       lookupAccess,
  input logic             regWrEn,
  input logic [IDX_W-1:0] regWrIdx,
  input logic [KEY_W-1:0] regWrKey,
  input logic [2:0]       regWrRights,
  input logic             regWrValid,
  input logic             flushReq,
  input logic             resultValid,
  input logic             keyMissFault,
  input logic             rightsFault,
  input logic [2:0]       effRights
);

  assert_exclusive_faults_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(keyMissFault && rightsFault));

  assert_quiet_without_lookup_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !resultValid && !keyMissFault && !rightsFault && (effRights == 3'b000));

  assert_miss_clears_rights_R3: assert property (@(posedge clk) disable iff (!rstN)
    keyMissFault |-> (effRights == 3'b000));

  assert_rights_within_translation_R4: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> ((effRights & ~$past(lookupRights)) == 3'b000));

  assert_fault_means_not_granted_R5: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (rightsFault == (!keyMissFault && ((effRights & needMask($past(lookupAccess))) == 3'b000))));

  assert_flush_empties_table_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushReq ##1 lookupValid |=> keyMissFault);

endmodule

bind prot_key_check key_check_sva #(.NUM_ENTRIES(NUM_ENTRIES), .KEY_W(KEY_W)) chk (.*);

// File: tb/prot_key_check_test.sv
`timescale 1ns/1ps
module prot_key_check_test;
  localparam int N  = 4;
  localparam int KW = 6;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [KW-1:0] lookupKey = '0;
  logic [2:0] lookupRights = '0;
  logic [1:0] lookupAccess = '0;
  logic regWrEn = 1'b0;
  logic [IW-1:0] regWrIdx = '0;
  logic [KW-1:0] regWrKey = '0;
  logic [2:0] regWrRights = '0;
  logic regWrValid = 1'b0;
  logic flushReq = 1'b0;
  logic resultValid, keyMissFault, rightsFault;
  logic [2:0] effRights;

  always #4 clk = ~clk;

  prot_key_check #(.NUM_ENTRIES(N), .KEY_W(KW)) uut (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model of the register set
  int refKey [N];
  int refRights [N];
  bit refValid [N];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag,
                      input bit lv, input int key, input int tr, input int acc,
                      input bit we, input int idx, input int wkey, input int wr, input bit wv,
                      input bit fl);
    int expRv, expMiss, expViol, expEff, need;
    bit hit;
    lookupValid = lv; lookupKey = KW'(key); lookupRights = 3'(tr); lookupAccess = 2'(acc);
    regWrEn = we; regWrIdx = IW'(idx); regWrKey = KW'(wkey); regWrRights = 3'(wr);
    regWrValid = wv; flushReq = fl;
    // expected verdict from the table before this cycle's update
    expRv = lv; expMiss = 0; expViol = 0; expEff = 0;
    if (lv) begin
      hit = 0;
      for (int j = 0; j < N; j++)
        if (refValid[j] && refKey[j] == key) begin hit = 1; expEff = refRights[j] & tr; end
      need = (acc == 0) ? 1 : (acc == 1) ? 2 : (acc == 2) ? 4 : 0;
      if (!hit) expMiss = 1;
      else expViol = ((expEff & need) == 0) ? 1 : 0;
    end
    // model update
    if (fl) begin
      for (int j = 0; j < N; j++) refValid[j] = 0;
    end else if (we) begin
      if (wv)
        for (int j = 0; j < N; j++)
          if (j != idx && refValid[j] && refKey[j] == wkey) refValid[j] = 0;
      refValid[idx] = wv; refKey[idx] = wkey; refRights[idx] = wr;
    end
    @(posedge clk);
    @(negedge clk);
    lookupValid = 0; regWrEn = 0; flushReq = 0;
    chk(tag, "resultValid", resultValid, expRv);
    chk(tag, "keyMissFault", keyMissFault, expMiss);
    chk(tag, "rightsFault", rightsFault, expViol);
    chk(tag, "effRights", effRights, expEff);
  endtask

  task automatic look(input string tag, input int key, input int tr, input int acc);
    step(tag, 1, key, tr, acc, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input string tag, input int idx, input int key, input int rights, input bit v);
    step(tag, 0, 0, 0, 0, 1, idx, key, rights, v, 0);
  endtask

  initial begin
    for (int j = 0; j < N; j++) begin refValid[j] = 0; refKey[j] = 0; refRights[j] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    chk("R1", "resultValid", resultValid, 0);
    chk("R1", "keyMissFault", keyMissFault, 0);
    chk("R1", "rightsFault", rightsFault, 0);
    chk("R1", "effRights", effRights, 0);
    rstN = 1'b1;
    look("R1", 0, 7, 0);                    // empty table: miss
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); // idle: no result
    look("R3", 5, 7, 0);
    // R7: lookup in the write cycle sees old table
    step("R7", 1, 5, 7, 0, 1, 0, 5, 7, 1, 0);
    look("R4", 5, 3, 0);                    // eff = 111 & 011
    look("R4", 5, 3, 2);                    // execute not granted -> R5
    wr("R7", 1, 9, 2, 1);                   // write-only key
    look("R5", 9, 7, 0);
    look("R5", 9, 7, 1);
    look("R5", 9, 6, 2);
    look("R5", 9, 7, 3);                    // code 11 always faults
    look("R4", 9, 0, 1);                    // translation grants nothing
    look("R3", 7, 7, 0);
    wr("R10", 3, 63, 4, 1);
    look("R10", 63, 7, 2);
    look("R10", 63, 5, 0);
    // R8: replacing write removes other copy
    wr("R8", 2, 5, 1, 1);
    look("R8", 5, 7, 0);
    look("R8", 5, 7, 1);
    wr("R8", 2, 5, 1, 0);
    look("R8", 5, 7, 0);                    // idx0 copy must be gone
    // R7: invalidate by writing valid=0
    wr("R7", 1, 9, 2, 0);
    look("R7", 9, 7, 1);
    // R9: flush with simultaneous write and lookup
    wr("R9", 0, 20, 7, 1);
    step("R9", 1, 63, 7, 2, 1, 1, 12, 7, 1, 1);
    look("R9", 63, 7, 2);
    look("R9", 12, 7, 0);
    look("R9", 20, 7, 0);
    // refill after flush, back-to-back lookups
    wr("R7", 2, 33, 7, 1);
    look("R2", 33, 7, 1);
    look("R2", 34, 7, 1);
    look("R6", 33, 1, 1);
    step("R2", 0, 33, 7, 0, 0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule